// File: doc/BRIEF.md
# Unit Clock Gate Controller with Busy Override

This block decides, for each of a set of transactional units, whether that unit's clock should run. Software places one hint bit per unit in a small register. A set hint keeps the clock running. A cleared hint allows the clock to stop, but only once the unit reports idle. A busy unit keeps its clock no matter what its hint says. A global clock-enable request can switch every unit off. An encoded scan-mode input can switch every unit on.

A readable status vector shows, per unit, whether the clock is currently held on by software or by activity. The status is the hint ORed with the unit's busy state. Software writes the hints and reads the status through a simple register port with separate write and read strobes. Read data is registered and appears one cycle after the request. The idle inputs come from other clock domains, so they pass through a two-stage synchronizer before they are used.

Top module: `unit_clk_gate_ctrl`

## Requirements
- R1: After reset the hint register holds all ones, every unit clock enable is high and the status vector reads all ones.
- R2: Once the inputs have settled, each status bit equals that unit's hint bit OR the inverse of its synchronized idle bit, so a busy unit always shows status 1.
- R3: When every unit is idle, the status vector equals the hint register exactly.
- R4: When all hints are set and all units are idle, the status vector reads all ones.
- R5: When the global enable is high and scan mode is not On, each unit enable follows its status bit. Clearing a busy unit's hint keeps its enable high. The enable falls on the third rising edge after the unit's idle input rises.
- R6: When the global enable input is low and scan mode is not On, every unit enable is 0 after the next rising edge, whatever the hints and idle inputs are.
- R7: When the scan-mode input equals the On code (4'b1010 by default), every unit enable is 1 after the next rising edge. This overrides the global enable. The Off code (4'b0101) and every other code act as normal operation.
- R8: The status output reflects a hint write after one rising edge and an idle-input change after two rising edges.
- R9: A write strobe with address 0 loads the write data into the hint register on that edge. Writes to any other address leave the hints unchanged.
- R10: A read strobe returns data on the read-data port after the next rising edge. Address 1 returns the status vector, address 0 returns the hint register, and any other address returns zero. The read data holds its value between reads.
- R11: The unit enable outputs are registered, so a change to the global enable or to scan mode reaches them after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address (0 hints, 1 status) |
| reg_wdata_i | input | NUM_UNITS | Write data for the hint register |
| reg_rdata_o | output | NUM_UNITS | Registered read data |
| unit_idle_i | input | NUM_UNITS | Per-unit idle indication, asynchronous |
| pwr_clk_en_i | input | 1 | Global clock-enable request |
| scan_mode_i | input | SCAN_W | Encoded scan-mode value |
| unit_clk_en_o | output | NUM_UNITS | Registered per-unit clock enables |
| hint_status_o | output | NUM_UNITS | Per-unit status (hint OR busy) |

## Verification
The properties assume that the strobes, the address, the global enable and scan mode are stable around each rising edge. They also assume that the idle vector is sampled only after its synchronizer. The properties that compare enables with status therefore use the synchronized idle value, not the raw input. The bench changes every input on the falling edge. It holds each pattern for at least three rising edges before it compares outputs, which covers the longest path from the idle input to the enables. It then sweeps all hint and idle combinations, every scan code and both global-enable levels.

// File: rtl/unit_clk_gate_pkg.sv
package unit_clk_gate_pkg;
    localparam int DEF_NUM_UNITS = 4;
    localparam int DEF_SCAN_W    = 4;
    localparam int DEF_ADDR_W    = 2;

    typedef enum logic [1:0] {
        SEL_HINT   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_NONE   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/unit_idle_sync.sv
module unit_idle_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    // Reset to busy so that no clock stops before the unit is sampled.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage2;
endmodule

// File: rtl/unit_hint_regs.sv
module unit_hint_regs
    import unit_clk_gate_pkg::*;
#(
    parameter int                NUM_UNITS   = 4,
    parameter int                ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] HINT_ADDR   = 0,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [NUM_UNITS-1:0] wdata_i,
    input  logic [NUM_UNITS-1:0] status_i,
    output logic [NUM_UNITS-1:0] hint_o,
    output logic [NUM_UNITS-1:0] rdata_o
);
    typedef struct packed {
        logic [NUM_UNITS-1:0] hint;
        logic [NUM_UNITS-1:0] rdata;
    } regs_state_t;

    regs_state_t st_d, st_q;
    reg_sel_e    sel;

    always_comb begin
        if (addr_i == HINT_ADDR) begin
            sel = SEL_HINT;
        end else if (addr_i == STATUS_ADDR) begin
            sel = SEL_STATUS;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_i && sel == SEL_HINT) begin
            st_d.hint = wdata_i;
        end
        if (rd_i) begin
            unique case (sel)
                SEL_HINT:   st_d.rdata = st_q.hint;
                SEL_STATUS: st_d.rdata = status_i;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.hint  <= '1;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hint_o  = st_q.hint;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/unit_gate_decide.sv
module unit_gate_decide #(
    parameter int                NUM_UNITS = 4,
    parameter int                SCAN_W    = 4,
    parameter logic [SCAN_W-1:0] SCAN_ON   = 4'b1010
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_UNITS-1:0] hint_i,
    input  logic [NUM_UNITS-1:0] idle_sync_i,
    input  logic                 clk_en_i,
    input  logic [SCAN_W-1:0]    scan_i,
    output logic [NUM_UNITS-1:0] status_o,
    output logic [NUM_UNITS-1:0] en_o
);
    typedef struct packed {
        logic [NUM_UNITS-1:0] en;
    } gate_state_t;

    gate_state_t          st_d, st_q;
    logic                 scan_active;
    logic [NUM_UNITS-1:0] keep_on;

    // Only the exact On code counts as scan; Off and invalid codes do not.
    assign scan_active = (scan_i == SCAN_ON);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign keep_on[u] = hint_i[u] | ~idle_sync_i[u];
    end

    always_comb begin
        st_d = st_q;
        if (scan_active) begin
            st_d.en = '1;
        end else if (!clk_en_i) begin
            st_d.en = '0;
        end else begin
            st_d.en = keep_on;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.en <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = keep_on;
    assign en_o     = st_q.en;
endmodule

// File: rtl/unit_clk_gate_ctrl.sv
module unit_clk_gate_ctrl
    import unit_clk_gate_pkg::*;
#(
    parameter int                NUM_UNITS   = DEF_NUM_UNITS,
    parameter int                SCAN_W      = DEF_SCAN_W,
    parameter int                ADDR_W      = DEF_ADDR_W,
    parameter logic [SCAN_W-1:0] SCAN_ON     = 4'b1010,
    parameter logic [ADDR_W-1:0] HINT_ADDR   = 0,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [NUM_UNITS-1:0] reg_wdata_i,
    output logic [NUM_UNITS-1:0] reg_rdata_o,
    input  logic [NUM_UNITS-1:0] unit_idle_i,
    input  logic                 pwr_clk_en_i,
    input  logic [SCAN_W-1:0]    scan_mode_i,
    output logic [NUM_UNITS-1:0] unit_clk_en_o,
    output logic [NUM_UNITS-1:0] hint_status_o
);
    logic [NUM_UNITS-1:0] hint_q;
    logic [NUM_UNITS-1:0] idle_sync;
    logic [NUM_UNITS-1:0] status;

    unit_idle_sync #(
        .WIDTH (NUM_UNITS)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (unit_idle_i),
        .sync_o  (idle_sync)
    );

    unit_hint_regs #(
        .NUM_UNITS   (NUM_UNITS),
        .ADDR_W      (ADDR_W),
        .HINT_ADDR   (HINT_ADDR),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status),
        .hint_o   (hint_q),
        .rdata_o  (reg_rdata_o)
    );

    unit_gate_decide #(
        .NUM_UNITS (NUM_UNITS),
        .SCAN_W    (SCAN_W),
        .SCAN_ON   (SCAN_ON)
    ) u_decide (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hint_i      (hint_q),
        .idle_sync_i (idle_sync),
        .clk_en_i    (pwr_clk_en_i),
        .scan_i      (scan_mode_i),
        .status_o    (status),
        .en_o        (unit_clk_en_o)
    );

    assign hint_status_o = status;
endmodule

// File: rtl/unit_clk_gate_chk.sv
module unit_clk_gate_chk #(
    parameter int                NUM_UNITS   = 4,
    parameter int                SCAN_W      = 4,
    parameter int                ADDR_W      = 2,
    parameter logic [SCAN_W-1:0] SCAN_ON     = 4'b1010,
    parameter logic [ADDR_W-1:0] HINT_ADDR   = 0,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 1
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 reg_wr_i,
    input logic                 reg_rd_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [NUM_UNITS-1:0] reg_wdata_i,
    input logic [NUM_UNITS-1:0] reg_rdata_o,
    input logic                 pwr_clk_en_i,
    input logic [SCAN_W-1:0]    scan_mode_i,
    input logic [NUM_UNITS-1:0] unit_clk_en_o,
    input logic [NUM_UNITS-1:0] hint_status_o,
    input logic [NUM_UNITS-1:0] hint_q,
    input logic [NUM_UNITS-1:0] idle_sync
);
    // R6
    gen_off_forces_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwr_clk_en_i && scan_mode_i != SCAN_ON) |=> (unit_clk_en_o == '0));

    // R7
    scan_forces_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_mode_i == SCAN_ON) |=> (unit_clk_en_o == '1));

    // R5
    busy_keeps_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_clk_en_i && scan_mode_i != SCAN_ON)
        |=> ((unit_clk_en_o & ~$past(idle_sync)) == ~$past(idle_sync)));

    // R9
    hint_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == HINT_ADDR) |=> (hint_q == $past(reg_wdata_i)));

    // R9
    hint_other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(reg_wr_i && reg_addr_i == HINT_ADDR)) |=> $stable(hint_q));

    // R10
    status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && reg_addr_i == STATUS_ADDR) |=> (reg_rdata_o == $past(hint_status_o)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reg_rd_i) |=> $stable(reg_rdata_o));
endmodule

bind unit_clk_gate_ctrl unit_clk_gate_chk #(
    .NUM_UNITS   (NUM_UNITS),
    .SCAN_W      (SCAN_W),
    .ADDR_W      (ADDR_W),
    .SCAN_ON     (SCAN_ON),
    .HINT_ADDR   (HINT_ADDR),
    .STATUS_ADDR (STATUS_ADDR)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_wr_i      (reg_wr_i),
    .reg_rd_i      (reg_rd_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .pwr_clk_en_i  (pwr_clk_en_i),
    .scan_mode_i   (scan_mode_i),
    .unit_clk_en_o (unit_clk_en_o),
    .hint_status_o (hint_status_o),
    .hint_q        (hint_q),
    .idle_sync     (idle_sync)
);

// File: tb/unit_clk_gate_ctrl_test.sv
module unit_clk_gate_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam logic [3:0] SCAN_ON_CODE  = 4'b1010;
    localparam logic [3:0] SCAN_OFF_CODE = 4'b0101;
    localparam logic [N-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr = 1'b0;
    logic         rd = 1'b0;
    logic [1:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] idle = '0;
    logic         gen = 1'b1;
    logic [3:0]   scan = SCAN_OFF_CODE;
    logic [N-1:0] en;
    logic [N-1:0] status;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    unit_clk_gate_ctrl uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .reg_wr_i      (wr),
        .reg_rd_i      (rd),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .unit_idle_i   (idle),
        .pwr_clk_en_i  (gen),
        .scan_mode_i   (scan),
        .unit_clk_en_o (en),
        .hint_status_o (status)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step(1);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [N-1:0] d);
        rd = 1'b1; addr = a;
        step(1);
        rd = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] rv;
        logic [N-1:0] exp;
        step(2);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 status", status, ALL1);
        check("R1 enables", en, ALL1);
        reg_read(2'd0, rv);
        check("R1 hint readback", rv, ALL1);

        // R2 R3 R4 R10 R5: full sweep of hints and idle
        for (int h = 0; h < 16; h++) begin
            for (int i = 0; i < 16; i++) begin
                reg_write(2'd0, N'(h));
                idle = N'(i);
                step(3);
                exp = N'(h) | ~N'(i);
                check("R2 status", status, exp);
                if (i == 15) check("R3 all idle", status, N'(h));
                if (i == 15 && h == 15) check("R4 all ones", status, ALL1);
                check("R5 enable follows status", en, exp);
                reg_read(2'd1, rv);
                check("R10 status read", rv, exp);
            end
        end

        // R8 latency of hint write and idle change
        idle = '1; step(3);
        reg_write(2'd0, 4'b0000);
        check("R8 hint after one edge", status, 4'b0000);
        idle = 4'b0110;
        step(1);
        check("R8 idle not yet seen", status, 4'b0000);
        step(1);
        check("R8 idle after two edges", status, 4'b1001);

        // R5 busy unit keeps its clock after hint cleared
        reg_write(2'd0, ALL1);
        idle = '0; step(3);
        reg_write(2'd0, 4'b0000);
        step(4);
        check("R5 busy keeps enable", en, ALL1);
        idle = 4'b0011;
        step(2);
        check("R5 enable before third edge", en, ALL1);
        step(1);
        check("R5 enable falls on third edge", en, 4'b1100);

        // R6 global enable low forces zero
        reg_write(2'd0, ALL1);
        idle = '0; step(3);
        gen = 1'b0;
        step(1);
        check("R6 gen low forces off", en, 4'b0000);
        scan = 4'b0000; step(1);
        check("R6 invalid scan no effect", en, 4'b0000);
        gen = 1'b1; scan = SCAN_OFF_CODE; step(1);
        check("R11 gen high after one edge", en, ALL1);

        // R7 R11: every scan code at both enable levels
        reg_write(2'd0, 4'b0101);
        idle = '1; step(3);
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 16; s++) begin
                gen = g[0];
                scan = 4'(s);
                step(1);
                if (4'(s) == SCAN_ON_CODE) exp = ALL1;
                else if (g == 1) exp = 4'b0101;
                else exp = 4'b0000;
                check("R7 scan code decode", en, exp);
            end
        end
        gen = 1'b1; scan = SCAN_OFF_CODE; step(1);

        // R9 writes to other addresses ignored
        reg_write(2'd0, 4'b1001);
        reg_write(2'd1, 4'b0110);
        reg_write(2'd2, 4'b0110);
        reg_write(2'd3, 4'b0110);
        reg_read(2'd0, rv);
        check("R9 hint unchanged by other addrs", rv, 4'b1001);
        check("R9 status reflects hint", status, 4'b1001);

        // R10 unknown address reads zero, read data holds
        reg_read(2'd3, rv);
        check("R10 unknown addr zero", rv, 4'b0000);
        reg_read(2'd0, rv);
        reg_write(2'd0, 4'b0011);
        step(2);
        check("R10 rdata holds", rdata, 4'b1001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule